// File: doc/BRIEF.md
# Program Memory Bank and Protect Unit

This block watches an 8-bit CPU bus and turns the CPU's 64 KB view into accesses to a larger program ROM and an 8 KB work RAM. Four register slots in the top 8 KB of the address map are written by the CPU. Three hold bank numbers for the 8 KB ROM windows at $8000, $A000 and $C000. The top window at $E000 always shows the last ROM bank. Each slot answers to a whole 2 KB address range.

The work RAM at $6000-$7FFF is selected for every strobed access in that range. Writes reach it only when the protect register holds an unlock key in its upper nibble and the 2 KB window being written is not marked protected. Three flag bits that other blocks use are also held here: a sound-disable flag and two pattern-RAM disable flags, one for each half of pattern memory. The block only exports these flags and does not act on them.

Top module: `pm_bank_protect`

## Requirements
- R1: After a synchronous active-low reset, all bank registers and the protect register are 0. The $8000 window then maps to ROM bank 0, all three flags are 0, and no RAM write is enabled.
- R2: Each register slot responds to every address in its 2 KB range: $E000-$E7FF, $E800-$EFFF, $F000-$F7FF and $F800-$FFFF.
- R3: For a strobed read with address bit 15 set, `rom_cs` is 1. `rom_addr` is {bank, cpu_addr[12:0]}. The bank comes from bits 5:0 of the $E000 slot for $8000-$9FFF, of the $E800 slot for $A000-$BFFF, and of the $F000 slot for $C000-$DFFF.
- R4: For any address in $E000-$FFFF, the bank field of `rom_addr` is all ones (bank 63), whatever the registers hold.
- R5: `sound_off` equals bit 6 of the $E000 slot.
- R6: `pat_ram_off_lo` equals bit 6 of the $E800 slot, which covers pattern addresses $0000-$0FFF. `pat_ram_off_hi` equals bit 7 of the same slot, which covers $1000-$1FFF.
- R7: `ram_cs` is 1 exactly when a strobed read or write targets $6000-$7FFF.
- R8: `ram_we` is 1 only for a strobed write in $6000-$7FFF. The protect register's bits 7:4 must equal 4'b0100. Its bit number cpu_addr[12:11] must be 0, where 1 means that 2 KB window is protected.
- R9: A register write takes effect at the clock edge that ends the write cycle. Writes to $8000-$DFFF, and reads anywhere, change no register.
- R10: Strobed reads of $6000-$7FFF assert `ram_cs` but never `ram_we`, whatever the key and protect bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_din | input | 8 | CPU write data |
| cyc_stb | input | 1 | One-cycle strobe framing a CPU access |
| cyc_rd | input | 1 | Read qualifier for the strobed cycle |
| cyc_wr | input | 1 | Write qualifier for the strobed cycle |
| rom_cs | output | 1 | Program ROM select |
| rom_addr | output | 19 | Extended program ROM address |
| ram_cs | output | 1 | Work RAM select |
| ram_we | output | 1 | Work RAM write enable |
| sound_off | output | 1 | Sound-disable flag |
| pat_ram_off_lo | output | 1 | Pattern RAM disable flag, lower 4 KB |
| pat_ram_off_hi | output | 1 | Pattern RAM disable flag, upper 4 KB |

## Verification
The hardest case to reach is the full product of protect states and RAM windows. A write lands only when the key nibble matches and the one protect bit picked by the target address is clear. Every other combination has to be seen to stay blocked. The stimulus covers this by writing each of the 256 protect values through a different mirror address in the $F800 range. After each value it probes a write and a read in all four 2 KB windows. Bank mapping is covered by sweeping all 64 bank numbers through each of the three bank slots, again through varying mirror addresses.

// File: rtl/pm_pkg.sv
// Package: constants shared by the program bank and protect unit.
// Assumes a 16-bit CPU address and 2 KB register decode granularity.
package pm_pkg;
    localparam int CPU_AW   = 16;
    localparam int CPU_DW   = 8;
    localparam int WIN_AW   = 13;          // 8 KB window offset width
    localparam int NSLOT    = 4;           // register slots at $E000..$F800
    localparam logic [3:0] UNLOCK_KEY = 4'b0100;
    localparam logic [2:0] REG_SPACE  = 3'b111;   // addr[15:13] of register slots
    localparam logic [2:0] RAM_SPACE  = 3'b011;   // addr[15:13] of work RAM
    typedef enum logic [1:0] {
        SLOT_BANK_A = 2'd0,
        SLOT_BANK_B = 2'd1,
        SLOT_BANK_C = 2'd2,
        SLOT_GUARD  = 2'd3
    } slot_e;
endpackage

// File: rtl/pm_bank_regs.sv
// Register file: four 8-bit slots loaded by CPU writes in $E000-$FFFF.
// Assumes the write qualifier is only trusted together with the strobe.
module pm_bank_regs
    import pm_pkg::*;
#(
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [4:0]        addr_hi,
    input  logic [CPU_DW-1:0] din,
    output logic [BANK_W-1:0] bank_a,
    output logic [BANK_W-1:0] bank_b,
    output logic [BANK_W-1:0] bank_c,
    output logic [CPU_DW-1:0] guard,
    output logic              snd_off,
    output logic              pat_lo_off,
    output logic              pat_hi_off
);
    logic [NSLOT-1:0][CPU_DW-1:0] slot_q;
    logic                         hit;
    logic [1:0]                   idx;

    // Decode which slot a write targets.
    always_comb begin
        hit = wr_stb && (addr_hi[4:2] == REG_SPACE);
        idx = addr_hi[1:0];
    end

    // Load the addressed slot at the end of a write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (hit && idx == i[1:0]) slot_q[i] <= din;
            end
        end
    end

    // Fan slot fields out to named controls.
    always_comb begin
        bank_a     = slot_q[SLOT_BANK_A][BANK_W-1:0];
        bank_b     = slot_q[SLOT_BANK_B][BANK_W-1:0];
        bank_c     = slot_q[SLOT_BANK_C][BANK_W-1:0];
        guard      = slot_q[SLOT_GUARD];
        snd_off    = slot_q[SLOT_BANK_A][6];
        pat_lo_off = slot_q[SLOT_BANK_B][6];
        pat_hi_off = slot_q[SLOT_BANK_B][7];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (slot_q == '0));
    // R9
    slot_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr_hi == 5'b11100) |=> (bank_a == $past(din[BANK_W-1:0])));
    // R9
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(slot_q));
endmodule

// File: rtl/pm_rom_map.sv
// ROM window mapper: picks the bank for the current 8 KB CPU window.
// Assumes the top window is hardwired to the last bank of the ROM.
module pm_rom_map
    import pm_pkg::*;
#(
    parameter int BANK_W = 6
) (
    input  logic [2:0]        win,
    input  logic [BANK_W-1:0] bank_a,
    input  logic [BANK_W-1:0] bank_b,
    input  logic [BANK_W-1:0] bank_c,
    output logic [BANK_W-1:0] bank_sel
);
    // Select the bank for the window given by addr[15:13].
    always_comb begin
        unique case (win)
            3'b100:  bank_sel = bank_a;
            3'b101:  bank_sel = bank_b;
            3'b110:  bank_sel = bank_c;
            3'b111:  bank_sel = '1;
            default: bank_sel = '0;
        endcase
    end
endmodule

// File: rtl/pm_ram_guard.sv
// Work RAM guard: chip select and keyed, per-2 KB write protection.
// Assumes guard[7:4] holds the key and guard[3:0] the protect bits.
module pm_ram_guard
    import pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              rd,
    input  logic              wr,
    input  logic [4:0]        addr_hi,
    input  logic [CPU_DW-1:0] guard,
    output logic              cs,
    output logic              we
);
    logic in_ram;
    logic unlocked;
    logic win_locked;

    // Work out range, key match and the protect bit of this window.
    always_comb begin
        in_ram     = (addr_hi[4:2] == RAM_SPACE);
        unlocked   = (guard[7:4] == UNLOCK_KEY);
        win_locked = guard[addr_hi[1:0]];
        cs         = stb && (rd || wr) && in_ram;
        we         = stb && wr && in_ram && unlocked && !win_locked;
    end

    // R8
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) we |-> cs);
    // R10
    we_never_read_chk: assert property (@(posedge clk) disable iff (!rst_n) (we |-> !rd));
endmodule

// File: rtl/pm_bank_protect.sv
// Top: program ROM banking and work RAM protection for an 8-bit CPU bus.
// Assumes one strobed CPU access per strobe cycle; outputs are combinational
// from the current bus and the registered slots.
module pm_bank_protect
    import pm_pkg::*;
#(
    parameter int BANK_W = 6,
    localparam int ROM_AW = BANK_W + WIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_din,
    input  logic              cyc_stb,
    input  logic              cyc_rd,
    input  logic              cyc_wr,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic              sound_off,
    output logic              pat_ram_off_lo,
    output logic              pat_ram_off_hi
);
    logic [BANK_W-1:0] bank_a, bank_b, bank_c, bank_sel;
    logic [7:0]        guard;
    logic              wr_stb;

    // Qualify writes with the cycle strobe.
    always_comb wr_stb = cyc_stb && cyc_wr;

    pm_bank_regs #(.BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr_hi(cpu_addr[15:11]),
        .din(cpu_din), .bank_a(bank_a), .bank_b(bank_b), .bank_c(bank_c),
        .guard(guard), .snd_off(sound_off), .pat_lo_off(pat_ram_off_lo),
        .pat_hi_off(pat_ram_off_hi)
    );

    pm_rom_map #(.BANK_W(BANK_W)) u_map (
        .win(cpu_addr[15:13]), .bank_a(bank_a), .bank_b(bank_b),
        .bank_c(bank_c), .bank_sel(bank_sel)
    );

    pm_ram_guard u_guard (
        .clk(clk), .rst_n(rst_n), .stb(cyc_stb), .rd(cyc_rd), .wr(cyc_wr),
        .addr_hi(cpu_addr[15:11]), .guard(guard), .cs(ram_cs), .we(ram_we)
    );

    // Form the ROM select and extended address.
    always_comb begin
        rom_cs   = cyc_stb && cyc_rd && cpu_addr[15];
        rom_addr = {bank_sel, cpu_addr[WIN_AW-1:0]};
    end

    // R4
    fixed_top_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && cpu_addr[15:13] == 3'b111) |-> (rom_addr[ROM_AW-1:WIN_AW] == '1));
    // R7
    ram_cs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> (cpu_addr[15:13] == 3'b011));
endmodule

// File: tb/tb_pm_bank_protect.sv
module tb_pm_bank_protect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_din = '0;
    logic        cyc_stb = 1'b0, cyc_rd = 1'b0, cyc_wr = 1'b0;
    logic        rom_cs, ram_cs, ram_we, sound_off, pat_ram_off_lo, pat_ram_off_hi;
    logic [18:0] rom_addr;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pm_bank_protect dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
        .cyc_stb(cyc_stb), .cyc_rd(cyc_rd), .cyc_wr(cyc_wr), .rom_cs(rom_cs),
        .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .sound_off(sound_off), .pat_ram_off_lo(pat_ram_off_lo),
        .pat_ram_off_hi(pat_ram_off_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write cycle, captured at the edge that ends it.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_din = d; cyc_stb = 1'b1; cyc_wr = 1'b1; cyc_rd = 1'b0;
        @(negedge clk);
        cyc_stb = 1'b0; cyc_wr = 1'b0;
    endtask

    // Present a strobed access mid-cycle and drop it before the next edge.
    task automatic probe(input logic [15:0] a, input logic rd, input logic wr);
        @(negedge clk);
        cpu_addr = a; cyc_stb = 1'b1; cyc_rd = rd; cyc_wr = wr;
        #1;
    endtask

    task automatic idle();
        #1;
        cyc_stb = 1'b0; cyc_rd = 1'b0; cyc_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        probe(16'h8123, 1'b1, 1'b0);
        check("R1 bank", rom_addr, 19'h00123);
        check("R1 flags", {sound_off, pat_ram_off_lo, pat_ram_off_hi}, 0);
        idle();
        probe(16'h6000, 1'b0, 1'b1);
        check("R1 we", ram_we, 0);
        idle();

        // R3 R2 bank sweeps through mirror addresses
        for (int s = 0; s < 3; s++) begin
            for (int b = 0; b < 64; b++) begin
                logic [15:0] wa, ra;
                wa = 16'hE000 + 16'(s * 16'h0800) + 16'((b * 37) & 16'h07FF);
                bus_write(wa, 8'(b));
                ra = 16'h8000 + 16'(s * 16'h2000) + 16'((b * 91) & 16'h1FFF);
                probe(ra, 1'b1, 1'b0);
                check("R3 R2 rom_addr", rom_addr, {6'(b), ra[12:0]});
                check("R3 rom_cs", rom_cs, 1);
                idle();
                probe(16'hE000 + 16'(b * 16'h7F), 1'b1, 1'b0);
                check("R4 top bank", rom_addr[18:13], 6'h3F);
                idle();
            end
        end

        // R5 R6 flags and R9 timing of the write
        @(negedge clk);
        cpu_addr = 16'hE7FF; cpu_din = 8'h45; cyc_stb = 1'b1; cyc_wr = 1'b1;
        #1 check("R9 before edge", sound_off, 0);
        @(negedge clk);
        cyc_stb = 1'b0; cyc_wr = 1'b0;
        check("R5 sound_off", sound_off, 1);
        bus_write(16'hE800, 8'h40);
        check("R6 lo", {pat_ram_off_hi, pat_ram_off_lo}, 2'b01);
        bus_write(16'hEC01, 8'h80);
        check("R6 hi", {pat_ram_off_hi, pat_ram_off_lo}, 2'b10);
        bus_write(16'hE000, 8'h05);
        check("R5 clear", sound_off, 0);

        // R9 writes below $E000 and reads at slots change nothing
        bus_write(16'h8000, 8'hFF);
        bus_write(16'hD800, 8'hFF);
        probe(16'hE000, 1'b1, 1'b0); idle();
        probe(16'h8010, 1'b1, 1'b0);
        check("R9 ignored", {sound_off, rom_addr}, {1'b0, 19'h0A010});
        idle();

        // R7 select outside range and without qualifiers
        probe(16'h5FFF, 1'b1, 1'b0);
        check("R7 below", ram_cs, 0); idle();
        probe(16'h8000, 1'b0, 1'b1);
        check("R7 above", ram_cs, 0); idle();

        // R8 R10 all protect values across all four windows
        for (int p = 0; p < 256; p++) begin
            bus_write(16'hF800 + 16'((p * 13) & 16'h07FF), 8'(p));
            for (int w = 0; w < 4; w++) begin
                logic [15:0] a;
                logic exp_we;
                a = 16'h6000 + 16'(w * 16'h0800) + 16'((p * 5) & 16'h07FF);
                exp_we = ((p >> 4) == 4) && (((p >> w) & 1) == 0);
                probe(a, 1'b0, 1'b1);
                check("R8 we", ram_we, 32'(exp_we));
                check("R7 cs wr", ram_cs, 1);
                idle();
                probe(a, 1'b1, 1'b0);
                check("R10 read", {ram_cs, ram_we}, 2'b10);
                idle();
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule